// File: doc/BRIEF.md
# Integer Multiply-Accumulate Execution Unit

This unit decodes and executes the multiply instruction group of a 32-bit load/store processor. Each valid cycle it takes one 32-bit instruction word and the register-file values already read for the four operand fields. One clock edge later it returns up to two register write-backs, a flag update for the negative and zero flags, and an illegal-encoding indication.

A single shared datapath serves all eight operations. These are the 32-bit multiply, multiply-add and multiply-subtract, and the signed and unsigned long multiplies with and without 64-bit accumulation. The eighth is an unsigned form that adds two independent 32-bit registers to a 64-bit product. The multiply-subtract and the double-accumulate forms can each be switched off by a parameter. When switched off, they decode as illegal.

The instruction layout is fixed. The low nibble of the opcode pattern sits at bits 7:4 and the class nibble at bits 27:24. Bits 23:21 pick the operation and bit 20 asks for flag update. Bits 19:16 hold the high or single destination, bits 15:12 the accumulate or low-destination field, bits 11:8 the first multiplicand and bits 3:0 the second. Bits 31:28 are ignored.

Top module: `mac_unit`

## Requirements
- R1: A word belongs to the group only when bits 27:24 are 0000 and bits 7:4 are 1001. Any other word gives illegal=1, with no write port and no flag enable.
- R2: Opcode 000 writes the low 32 bits of rm×rn to the register in bits 19:16 on port 0 only. If bits 15:12 are not zero, the word is illegal.
- R3: Opcode 001 writes the low 32 bits of rm×rn plus the bits-15:12 operand to the bits-19:16 register on port 0 only.
- R4: Opcode 011 writes the bits-15:12 operand minus rm×rn, modulo 2^32, to the bits-19:16 register on port 0. When HAS_MLS is 0 it is illegal.
- R5: Opcodes 100 (unsigned) and 110 (signed) form the full 64-bit product. The low word goes on port 0 to the bits-15:12 index and the high word on port 1 to the bits-19:16 index.
- R6: Opcodes 101 (unsigned) and 111 (signed) add the 64-bit value {bits-19:16 operand, bits-15:12 operand} to the product. The low word goes to the bits-15:12 index and the high word to the bits-19:16 index.
- R7: Opcode 010 adds both 32-bit operands, zero-extended, to the unsigned 64-bit product and writes the result split as in R6. When HAS_UMAAL is 0 it is illegal.
- R8: Opcodes 010 and 011 with bit 20 set are illegal.
- R9: With bit 20 set on opcode 000 or 001, the negative/zero flag enable is raised. N is result bit 31, and Z is 1 exactly when the 32-bit result is zero.
- R10: With bit 20 set on a long form, N is bit 63 of the result, and Z is 1 only when all 64 bits are zero.
- R11: The carry/overflow flag enable is never raised. With bit 20 clear, the negative/zero enable stays low. An illegal word raises no enable at all.
- R12: All outputs are zero during reset. Results appear with out_valid exactly one cycle after in_valid. In a cycle without in_valid, no enable and no illegal indication is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands present |
| instr | input | 32 | Instruction word |
| rd_val | input | 32 | Value of register named by bits 19:16 |
| ra_val | input | 32 | Value of register named by bits 15:12 |
| rm_val | input | 32 | Value of register named by bits 11:8 |
| rn_val | input | 32 | Value of register named by bits 3:0 |
| out_valid | output | 1 | Result of previous cycle's instruction |
| illegal | output | 1 | Word was not a legal multiply encoding |
| wp0_en | output | 1 | Write port 0 enable |
| wp0_idx | output | 4 | Write port 0 register index |
| wp0_data | output | 32 | Write port 0 data (single result or low word) |
| wp1_en | output | 1 | Write port 1 enable |
| wp1_idx | output | 4 | Write port 1 register index |
| wp1_data | output | 32 | Write port 1 data (high word) |
| flag_nz_we | output | 1 | Negative/zero flag write enable |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_cv_we | output | 1 | Carry/overflow write enable, always low |

## Verification
Several relations among the outputs are checked on every cycle. Idle and illegal cycles must stay quiet. Port 1 is never enabled without port 0. The flag values must agree with the write data that goes out beside them, at 32-bit and 64-bit width. A word outside the group must come back illegal one cycle later. Only the bench scenarios can show that the arithmetic itself is right. That covers signed against unsigned extension, the accumulate and subtract wrap-around, the double-accumulate sum near 2^64, and the placement of indices on each port. The scenarios also cover the parameter gating, which a second instance with both options off makes visible.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned XW    = 32;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [2:0] {
    OP_MUL   = 3'b000,
    OP_MLA   = 3'b001,
    OP_UMAAL = 3'b010,
    OP_MLS   = 3'b011,
    OP_UMULL = 3'b100,
    OP_UMLAL = 3'b101,
    OP_SMULL = 3'b110,
    OP_SMLAL = 3'b111
  } mac_op_e;

  typedef struct packed {
    logic             legal;
    mac_op_e          op;
    logic             setf;
    logic             is_long;
    logic             is_signed;
    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;
  } mac_dec_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
#(
  parameter bit HAS_MLS   = 1'b1,
  parameter bit HAS_UMAAL = 1'b1
) (
  input  logic [XW-1:0] instr,
  output mac_dec_t      dec
);
  logic in_group;
  logic unused_fields;

  assign unused_fields = ^{instr[31:28], instr[11:8], instr[3:0]};
  assign in_group      = (instr[27:24] == 4'b0000) && (instr[7:4] == 4'b1001);

  always_comb begin
    dec.op        = mac_op_e'(instr[23:21]);
    dec.setf      = instr[20];
    dec.hi_idx    = instr[19:16];
    dec.lo_idx    = instr[15:12];
    dec.is_long   = instr[23] | (dec.op == OP_UMAAL);
    dec.is_signed = instr[23] & instr[22];
    dec.legal     = in_group;
    if ((dec.op == OP_MUL) && (dec.lo_idx != '0))              dec.legal = 1'b0;
    if (((dec.op == OP_UMAAL) || (dec.op == OP_MLS)) && dec.setf) dec.legal = 1'b0;
    if ((dec.op == OP_MLS) && !HAS_MLS)                         dec.legal = 1'b0;
    if ((dec.op == OP_UMAAL) && !HAS_UMAAL)                     dec.legal = 1'b0;
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
(
  input  mac_dec_t      dec,
  input  logic [XW-1:0] rd_val,
  input  logic [XW-1:0] ra_val,
  input  logic [XW-1:0] rm_val,
  input  logic [XW-1:0] rn_val,
  output logic [XW-1:0] res_lo,
  output logic [XW-1:0] res_hi
);
  localparam int unsigned DW = 2 * XW;

  logic signed [XW:0]     opa_x;
  logic signed [XW:0]     opb_x;
  logic signed [DW+1:0]   prod_full;
  logic        [DW-1:0]   prod;
  logic        [DW-1:0]   acc;
  logic        [DW-1:0]   sum;
  logic                   unused_prod;

  // one shared 33x33 signed multiplier; the extra bit selects the extension
  assign opa_x       = $signed({dec.is_signed & rm_val[XW-1], rm_val});
  assign opb_x       = $signed({dec.is_signed & rn_val[XW-1], rn_val});
  assign prod_full   = opa_x * opb_x;
  assign prod        = prod_full[DW-1:0];
  assign unused_prod = ^prod_full[DW+1:DW];

  always_comb begin
    unique case (dec.op)
      OP_MLA:             acc = {{XW{1'b0}}, ra_val};
      OP_UMLAL, OP_SMLAL: acc = {rd_val, ra_val};
      OP_UMAAL:           acc = {{XW{1'b0}}, ra_val} + {{XW{1'b0}}, rd_val};
      default:            acc = '0;
    endcase
  end

  assign sum = prod + acc;

  always_comb begin
    res_hi = sum[DW-1:XW];
    if (dec.op == OP_MLS) res_lo = ra_val - prod[XW-1:0];
    else                  res_lo = sum[XW-1:0];
  end
endmodule

// File: rtl/mac_writeback.sv
module mac_writeback
  import mac_pkg::*;
(
  input  mac_dec_t         dec,
  input  logic [XW-1:0]    res_lo,
  input  logic [XW-1:0]    res_hi,
  output logic             wb0_en,
  output logic [IDX_W-1:0] wb0_idx,
  output logic [XW-1:0]    wb0_data,
  output logic             wb1_en,
  output logic [IDX_W-1:0] wb1_idx,
  output logic [XW-1:0]    wb1_data,
  output logic             nz_we,
  output logic             n_val,
  output logic             z_val
);
  always_comb begin
    wb0_en   = dec.legal;
    wb0_data = res_lo;
    wb1_en   = dec.legal & dec.is_long;
    wb1_idx  = dec.is_long ? dec.hi_idx : '0;
    wb1_data = dec.is_long ? res_hi : '0;
    wb0_idx  = dec.is_long ? dec.lo_idx : dec.hi_idx;
    nz_we    = dec.legal & dec.setf;
    if (dec.is_long) begin
      n_val = res_hi[XW-1];
      z_val = ({res_hi, res_lo} == '0);
    end else begin
      n_val = res_lo[XW-1];
      z_val = (res_lo == '0);
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter bit HAS_MLS   = 1'b1,
  parameter bit HAS_UMAAL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic [31:0] rd_val,
  input  logic [31:0] ra_val,
  input  logic [31:0] rm_val,
  input  logic [31:0] rn_val,
  output logic        out_valid,
  output logic        illegal,
  output logic        wp0_en,
  output logic [3:0]  wp0_idx,
  output logic [31:0] wp0_data,
  output logic        wp1_en,
  output logic [3:0]  wp1_idx,
  output logic [31:0] wp1_data,
  output logic        flag_nz_we,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_cv_we
);
  mac_dec_t         dec;
  logic [XW-1:0]    res_lo, res_hi;
  logic             c_wb0_en, c_wb1_en, c_nz_we, c_n, c_z;
  logic [IDX_W-1:0] c_wb0_idx, c_wb1_idx;
  logic [XW-1:0]    c_wb0_data, c_wb1_data;

  logic             nxt_vld, nxt_ill, nxt_e0, nxt_e1, nxt_nzwe, nxt_n, nxt_z;
  logic [IDX_W-1:0] nxt_i0, nxt_i1;
  logic [XW-1:0]    nxt_d0, nxt_d1;

  mac_decode #(.HAS_MLS(HAS_MLS), .HAS_UMAAL(HAS_UMAAL)) u_dec (
    .instr (instr),
    .dec   (dec)
  );

  mac_datapath u_dp (
    .dec    (dec),
    .rd_val (rd_val),
    .ra_val (ra_val),
    .rm_val (rm_val),
    .rn_val (rn_val),
    .res_lo (res_lo),
    .res_hi (res_hi)
  );

  mac_writeback u_wb (
    .dec      (dec),
    .res_lo   (res_lo),
    .res_hi   (res_hi),
    .wb0_en   (c_wb0_en),
    .wb0_idx  (c_wb0_idx),
    .wb0_data (c_wb0_data),
    .wb1_en   (c_wb1_en),
    .wb1_idx  (c_wb1_idx),
    .wb1_data (c_wb1_data),
    .nz_we    (c_nz_we),
    .n_val    (c_n),
    .z_val    (c_z)
  );

  // next state: enables follow in_valid, data and indices hold while idle
  always_comb begin
    nxt_vld  = in_valid;
    nxt_ill  = in_valid & ~dec.legal;
    nxt_e0   = in_valid & c_wb0_en;
    nxt_e1   = in_valid & c_wb1_en;
    nxt_nzwe = in_valid & c_nz_we;
    nxt_i0   = wp0_idx;
    nxt_i1   = wp1_idx;
    nxt_d0   = wp0_data;
    nxt_d1   = wp1_data;
    nxt_n    = flag_n;
    nxt_z    = flag_z;
    if (in_valid) begin
      nxt_i0 = c_wb0_idx;
      nxt_i1 = c_wb1_idx;
      nxt_d0 = c_wb0_data;
      nxt_d1 = c_wb1_data;
      nxt_n  = c_n;
      nxt_z  = c_z;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      illegal    <= 1'b0;
      wp0_en     <= 1'b0;
      wp1_en     <= 1'b0;
      flag_nz_we <= 1'b0;
      wp0_idx    <= '0;
      wp1_idx    <= '0;
      wp0_data   <= '0;
      wp1_data   <= '0;
      flag_n     <= 1'b0;
      flag_z     <= 1'b0;
    end else begin
      out_valid  <= nxt_vld;
      illegal    <= nxt_ill;
      wp0_en     <= nxt_e0;
      wp1_en     <= nxt_e1;
      flag_nz_we <= nxt_nzwe;
      wp0_idx    <= nxt_i0;
      wp1_idx    <= nxt_i1;
      wp0_data   <= nxt_d0;
      wp1_data   <= nxt_d1;
      flag_n     <= nxt_n;
      flag_z     <= nxt_z;
    end
  end

  assign flag_cv_we = 1'b0;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  grp_bits,
  input logic        out_valid,
  input logic        illegal,
  input logic        wp0_en,
  input logic        wp1_en,
  input logic [31:0] wp0_data,
  input logic [31:0] wp1_data,
  input logic        flag_nz_we,
  input logic        flag_n,
  input logic        flag_z
);
  // R12
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R12
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wp0_en && !wp1_en && !flag_nz_we && !illegal));
  // R11
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wp0_en && !wp1_en && !flag_nz_we));
  // R1
  group_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && grp_bits != 8'b0000_1001) |=> illegal);
  // R5
  port_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp1_en |-> wp0_en);
  // R10
  long_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_nz_we && wp1_en) |->
      (flag_z == ({wp1_data, wp0_data} == 64'd0) && flag_n == wp1_data[31]));
  // R9
  short_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_nz_we && !wp1_en) |->
      (flag_z == (wp0_data == 32'd0) && flag_n == wp0_data[31]));
endmodule

bind mac_unit mac_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .grp_bits   ({instr[27:24], instr[7:4]}),
  .out_valid  (out_valid),
  .illegal    (illegal),
  .wp0_en     (wp0_en),
  .wp1_en     (wp1_en),
  .wp0_data   (wp0_data),
  .wp1_data   (wp1_data),
  .flag_nz_we (flag_nz_we),
  .flag_n     (flag_n),
  .flag_z     (flag_z)
);

// File: tb/mac_unit_tb.sv
`timescale 1ns/1ps
module mac_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, rd_val = '0, ra_val = '0, rm_val = '0, rn_val = '0;

  logic        a_vld, a_ill, a_e0, a_e1, a_nzwe, a_n, a_z, a_cv;
  logic [3:0]  a_i0, a_i1;
  logic [31:0] a_d0, a_d1;
  logic        b_vld, b_ill, b_e0, b_e1, b_nzwe, b_n, b_z, b_cv;
  logic [3:0]  b_i0, b_i1;
  logic [31:0] b_d0, b_d1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rd_val(rd_val), .ra_val(ra_val), .rm_val(rm_val), .rn_val(rn_val),
    .out_valid(a_vld), .illegal(a_ill), .wp0_en(a_e0), .wp0_idx(a_i0),
    .wp0_data(a_d0), .wp1_en(a_e1), .wp1_idx(a_i1), .wp1_data(a_d1),
    .flag_nz_we(a_nzwe), .flag_n(a_n), .flag_z(a_z), .flag_cv_we(a_cv)
  );

  mac_unit #(.HAS_MLS(1'b0), .HAS_UMAAL(1'b0)) u_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rd_val(rd_val), .ra_val(ra_val), .rm_val(rm_val), .rn_val(rn_val),
    .out_valid(b_vld), .illegal(b_ill), .wp0_en(b_e0), .wp0_idx(b_i0),
    .wp0_data(b_d0), .wp1_en(b_e1), .wp1_idx(b_i1), .wp1_data(b_d1),
    .flag_nz_we(b_nzwe), .flag_n(b_n), .flag_z(b_z), .flag_cv_we(b_cv)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] op, input logic s, input logic [3:0] rd,
                                     input logic [3:0] ra, input logic [3:0] rm, input logic [3:0] rn);
    return {4'hE, 4'b0000, op, s, rd, ra, rm, 4'b1001, rn};
  endfunction

  // independent reference built from the requirement text
  task automatic judge(input bit mls_on, input bit umaal_on,
                       input logic vld, ill, e0, e1, nzwe, n, z, cv,
                       input logic [3:0] i0, i1, input logic [31:0] d0, d1);
    logic        grp, s, lng, x_ill, x_nz, x_n, x_z;
    logic [2:0]  op;
    logic [3:0]  x_i0, x_i1;
    logic [63:0] u, sg, r;
    logic [14:0] act_c, exp_c;
    string       ctag, dtag;
    grp = (instr[27:24] == 4'h0) && (instr[7:4] == 4'h9);
    op  = instr[23:21];
    s   = instr[20];
    lng = op[2] || (op == 3'b010);
    u   = {32'd0, rm_val} * {32'd0, rn_val};
    sg  = {{32{rm_val[31]}}, rm_val} * {{32{rn_val[31]}}, rn_val};
    x_ill = 1'b0;
    ctag  = s ? (lng ? "R10" : "R9") : "R11";
    if (!grp)                                   begin x_ill = 1'b1; ctag = "R1"; end
    else if (op == 3'b000 && instr[15:12] != 0) begin x_ill = 1'b1; ctag = "R2"; end
    else if ((op == 3'b010 || op == 3'b011) && s) begin x_ill = 1'b1; ctag = "R8"; end
    else if (op == 3'b011 && !mls_on)           begin x_ill = 1'b1; ctag = "R4"; end
    else if (op == 3'b010 && !umaal_on)         begin x_ill = 1'b1; ctag = "R7"; end
    case (op)
      3'b000:  begin r = {32'd0, u[31:0]};                         dtag = "R2"; end
      3'b001:  begin r = {32'd0, u[31:0] + ra_val};                dtag = "R3"; end
      3'b011:  begin r = {32'd0, ra_val - u[31:0]};                dtag = "R4"; end
      3'b100:  begin r = u;                                        dtag = "R5"; end
      3'b110:  begin r = sg;                                       dtag = "R5"; end
      3'b101:  begin r = u + {rd_val, ra_val};                     dtag = "R6"; end
      3'b111:  begin r = sg + {rd_val, ra_val};                    dtag = "R6"; end
      default: begin r = u + {32'd0, ra_val} + {32'd0, rd_val};    dtag = "R7"; end
    endcase
    x_i0 = lng ? instr[15:12] : instr[19:16];
    x_i1 = instr[19:16];
    x_nz = s && !x_ill;
    x_n  = lng ? r[63] : r[31];
    x_z  = lng ? (r == 64'd0) : (r[31:0] == 32'd0);
    act_c = {vld, ill, e0, e0 ? i0 : 4'h0, e1, e1 ? i1 : 4'h0, nzwe, nzwe & n, nzwe & z, cv};
    exp_c = {1'b1, x_ill, !x_ill, !x_ill ? x_i0 : 4'h0, !x_ill && lng, (!x_ill && lng) ? x_i1 : 4'h0,
             x_nz, x_nz & x_n, x_nz & x_z, 1'b0};
    check(act_c == exp_c, ctag, {49'd0, act_c}, {49'd0, exp_c});
    if (!x_ill) begin
      if (lng) check({d1, d0} == r, dtag, {d1, d0}, r);
      else     check(d0 == r[31:0], dtag, {32'd0, d0}, r);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] vd, va, vm, vn);
    instr = ins; rd_val = vd; ra_val = va; rm_val = vm; rn_val = vn; in_valid = 1'b1;
    @(negedge clk);
    judge(1'b1, 1'b1, a_vld, a_ill, a_e0, a_e1, a_nzwe, a_n, a_z, a_cv, a_i0, a_i1, a_d0, a_d1);
    judge(1'b0, 1'b0, b_vld, b_ill, b_e0, b_e1, b_nzwe, b_n, b_z, b_cv, b_i0, b_i1, b_d0, b_d1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [5];
    corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF; corner[2] = 32'h8000_0000;
    corner[3] = 32'h0000_0001; corner[4] = 32'h7FFF_FFFF;
    repeat (3) @(negedge clk);
    // R12: reset state
    check({a_vld, a_ill, a_e0, a_e1, a_nzwe, a_cv, a_d0, a_d1} == '0, "R12",
          {a_vld, a_ill, a_e0, a_e1, a_nzwe, a_d0}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 8; op++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++)
            apply(mk(3'(op), 1'(s), 4'hA, (op == 0) ? 4'h0 : 4'h3, 4'h2, 4'h9),
                  corner[(i + j) % 5], corner[(i + 2 * j) % 5], corner[i], corner[j]);
    // R7: double accumulate at the top of the 64-bit range
    apply(mk(3'b010, 1'b0, 4'h1, 4'h2, 4'h3, 4'h4), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R10: long zero result
    apply(mk(3'b111, 1'b1, 4'h5, 4'h6, 4'h7, 4'h8), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001);
    // R2: nonzero accumulate field on plain multiply
    apply(mk(3'b000, 1'b0, 4'h5, 4'h4, 4'h7, 4'h8), 32'd1, 32'd2, 32'd3, 32'd4);
    // R1: words outside the group
    apply({4'hE, 4'b0001, 3'b001, 1'b1, 16'h1234, 4'b1001, 4'h5}, 32'd1, 32'd2, 32'd3, 32'd4);
    apply({4'hE, 4'b0000, 3'b100, 1'b0, 16'h1234, 4'b1011, 4'h5}, 32'd1, 32'd2, 32'd3, 32'd4);
    for (int k = 0; k < 200; k++)
      apply(mk(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 4'($urandom), 4'hC, 4'($urandom), 4'($urandom)),
            $urandom, $urandom, $urandom, $urandom);
    // R12: no in_valid -> quiet outputs
    in_valid = 1'b0;
    @(negedge clk);
    check({a_vld, a_ill, a_e0, a_e1, a_nzwe} == '0, "R12", {59'd0, a_vld, a_ill, a_e0, a_e1, a_nzwe}, 64'd0);
    check({b_vld, b_ill, b_e0, b_e1, b_nzwe} == '0, "R12", {59'd0, b_vld, b_ill, b_e0, b_e1, b_nzwe}, 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule